// File: doc/BRIEF.md
# Low-Frequency Sample Capture with Level Trigger

This block sits between a low-frequency reader front end and an 8-bit ADC. It turns a single programmable divisor into two clocks. One is the antenna drive clock. The other is the ADC sampling clock, which runs in antiphase to the drive clock. On each rising edge of the ADC clock it can record one sample into an on-chip buffer.

A 16-bit command word sets the divisor, or else the operating mode and the field option. A start pulse arms a capture. If the trigger is enabled, samples are thrown away until the first one reaches a programmed level. From that sample on, every sample is kept until the buffer is full. Then a done flag rises, and the buffer can be read through a synchronous address/data port.

When the field option is cleared, the antenna is no longer driven but the ADC clock keeps running. This lets the block listen passively to another reader's field.

Top module: `lf_capture_top`

## Requirements
- R1: A command word whose bits [15:12] equal 2 loads the divisor from bits [11:0]. The divided clock toggles each time an internal counter reaches the divisor, so its period is 2*(divisor+1) system clocks. The counter restarts on every divisor write.
- R2: A divisor value of 1, or any value above 255, is replaced by the default value 95, which is the 125 kHz setting. After reset the divisor is also 95.
- R3: The ADC clock output is the inverse of the divided clock. It toggles in every mode, whether or not the field is enabled.
- R4: A command word whose bits [15:12] equal 1 writes the mode from bits [7:5] and the field enable from bit 0. The mode codes are 0 for ADC read, 1 for edge detect, 2 for passthrough and 7 for off. The antenna drive equals the divided clock only in ADC read mode with the field enabled; in every other case it is held low.
- R5: A start pulse is accepted only in ADC read mode. In any other mode it is ignored: no capture begins and the done flag keeps its value.
- R6: Each sample is taken on a rising edge of the ADC clock. While the trigger is armed, a sample below the threshold is discarded and the write address does not advance. The first sample greater than or equal to the threshold is stored. Every later sample is then stored, whatever its value.
- R7: A threshold of all ones (511 on the 9-bit trig_level input) disables the trigger, so the first sample after start and every one after it are stored.
- R8: When DEPTH samples have been stored, busy falls and done rises. Both change on the same clock edge that stores the last sample.
- R9: A start pulse during a capture is ignored and changes neither busy nor the write position. Done stays set until the next accepted start, which clears it.
- R10: After reset the mode is off, the field is disabled, and busy and done are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Opcode in [15:12], argument below it |
| trig_level | input | 9 | Trigger threshold, latched at start; all ones disables the trigger |
| start | input | 1 | Arm a capture (one-cycle pulse) |
| adc_sample | input | 8 | ADC result |
| rd_addr | input | $clog2(DEPTH) | Buffer read address |
| rd_data | output | 8 | Buffer word, valid one clock after rd_addr |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Buffer full |
| ant_drive | output | 1 | Antenna drive clock |
| adc_clk_out | output | 1 | ADC sampling clock |

## Verification
Three kinds of internal fault show at the ports in different ways:

- **Wrong divider count.** The period of adc_clk_out changes within two clock periods.
- **Trigger that stays armed, or disarms too early.** The stored sequence shifts against the sample stream. This shows on the first word read back.
- **Wrong write pointer.** Done rises early or late against the number of rising edges of the ADC clock, so the fault appears on the edge that should have finished the capture.

The bench keeps its own sample stream and trigger model. It compares the buffer against them word by word, and checks the done edge at the exact strobe where the model finishes.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
  localparam logic [3:0] OP_CFG = 4'h1;
  localparam logic [3:0] OP_DIV = 4'h2;

  localparam logic [2:0] MODE_ADC  = 3'd0;
  localparam logic [2:0] MODE_EDGE = 3'd1;
  localparam logic [2:0] MODE_PASS = 3'd2;
  localparam logic [2:0] MODE_OFF  = 3'd7;
endpackage

// File: rtl/lfc_cmd_decode.sv
module lfc_cmd_decode #(
  parameter int DIV_W       = 8,
  parameter int ARG_W       = 12,
  parameter int DEFAULT_DIV = 95
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [15:0]      cmd_word,
  output logic [DIV_W-1:0] div_q,
  output logic             div_load,
  output logic [2:0]       mode_q,
  output logic             field_q
);
  import lfc_pkg::*;

  localparam int DIV_MAX = (1 << DIV_W) - 1;

  logic [3:0]       opcode;
  logic [ARG_W-1:0] arg;
  logic             arg_bad;

  assign opcode   = cmd_word[15:12];
  assign arg      = cmd_word[ARG_W-1:0];
  assign arg_bad  = (arg == ARG_W'(1)) || (arg > ARG_W'(DIV_MAX));
  // divider restarts on the same edge the new divisor lands
  assign div_load = cmd_valid && (opcode == OP_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= DIV_W'(DEFAULT_DIV);
      mode_q  <= MODE_OFF;
      field_q <= 1'b0;
    end else if (cmd_valid) begin
      case (opcode)
        OP_DIV: div_q <= arg_bad ? DIV_W'(DEFAULT_DIV) : arg[DIV_W-1:0];
        OP_CFG: begin
          mode_q  <= cmd_word[7:5];
          field_q <= cmd_word[0];
        end
        default: ;
      endcase
    end
  end

  AST_BAD_DIV_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && opcode == OP_DIV && arg_bad) |=> (div_q == DIV_W'(DEFAULT_DIV))); // R2
endmodule

// File: rtl/lfc_clkdiv.sv
module lfc_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_q,
  input  logic             div_load,
  output logic             divclk,
  output logic             sample_stb
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap       = (cnt == div_q);
  // divided clock about to fall == ADC clock about to rise
  assign sample_stb = wrap && divclk && !div_load;

  always_ff @(posedge clk) begin
    if (rst || div_load) begin
      cnt    <= '0;
      divclk <= 1'b0;
    end else if (wrap) begin
      cnt    <= '0;
      divclk <= ~divclk;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= div_q); // R1
endmodule

// File: rtl/lfc_capture.sv
module lfc_capture #(
  parameter int DEPTH  = 32,
  parameter int SAMP_W = 8,
  parameter int THR_W  = SAMP_W + 1,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start,
  input  logic              sample_stb,
  input  logic [SAMP_W-1:0] sample,
  input  logic [THR_W-1:0]  trig_level,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic              busy,
  output logic              done
);
  localparam logic [THR_W-1:0] THR_OFF = '1;

  logic [AW:0]      wptr;
  logic             armed;
  logic [THR_W-1:0] thr_q;
  logic             below;

  assign below   = armed && ({1'b0, sample} < thr_q);
  assign wr_en   = busy && enable && sample_stb && !below;
  assign wr_addr = wptr[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      wptr  <= '0;
      armed <= 1'b0;
      thr_q <= '0;
    end else if (start && !busy && enable) begin
      busy  <= 1'b1;
      done  <= 1'b0;
      wptr  <= '0;
      armed <= (trig_level != THR_OFF);
      thr_q <= trig_level;
    end else if (wr_en) begin
      wptr  <= wptr + 1'b1;
      armed <= 1'b0;
      if (wptr == (AW+1)'(DEPTH - 1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wptr <= (AW+1)'(DEPTH)); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !wr_en) |=> (busy && $stable(wptr))); // R9
endmodule

// File: rtl/lfc_sample_ram.sv
module lfc_sample_ram #(
  parameter int DEPTH  = 32,
  parameter int SAMP_W = 8,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [SAMP_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [SAMP_W-1:0] rd_data
);
  logic [SAMP_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/lf_capture_top.sv
module lf_capture_top #(
  parameter int DEPTH       = 32,
  parameter int SAMP_W      = 8,
  parameter int DIV_W       = 8,
  parameter int DEFAULT_DIV = 95,
  parameter int THR_W       = SAMP_W + 1,
  parameter int AW          = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [15:0]       cmd_word,
  input  logic [THR_W-1:0]  trig_level,
  input  logic              start,
  input  logic [SAMP_W-1:0] adc_sample,
  input  logic [AW-1:0]     rd_addr,
  output logic [SAMP_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              ant_drive,
  output logic              adc_clk_out
);
  import lfc_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic             div_load;
  logic [2:0]       mode_q;
  logic             field_q;
  logic             divclk;
  logic             sample_stb;
  logic             adc_mode;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;

  lfc_cmd_decode #(.DIV_W(DIV_W), .ARG_W(12), .DEFAULT_DIV(DEFAULT_DIV)) u_dec (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .div_q(div_q), .div_load(div_load), .mode_q(mode_q), .field_q(field_q)
  );

  lfc_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div_q(div_q), .div_load(div_load),
    .divclk(divclk), .sample_stb(sample_stb)
  );

  assign adc_mode    = (mode_q == MODE_ADC);
  assign ant_drive   = divclk & field_q & adc_mode;
  assign adc_clk_out = ~divclk;

  lfc_capture #(.DEPTH(DEPTH), .SAMP_W(SAMP_W), .THR_W(THR_W), .AW(AW)) u_cap (
    .clk(clk), .rst(rst), .enable(adc_mode), .start(start),
    .sample_stb(sample_stb), .sample(adc_sample), .trig_level(trig_level),
    .wr_en(wr_en), .wr_addr(wr_addr), .busy(busy), .done(done)
  );

  lfc_sample_ram #(.DEPTH(DEPTH), .SAMP_W(SAMP_W), .AW(AW)) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(adc_sample),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/sim_lf_capture_top.sv
module sim_lf_capture_top;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [8:0]  trig_level = 9'h1FF;
  logic start = 1'b0;
  logic [7:0]  adc_sample = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic busy, done, ant_drive, adc_clk_out;

  always #2.5 clk = ~clk;

  lf_capture_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .trig_level(trig_level), .start(start), .adc_sample(adc_sample),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
    .ant_drive(ant_drive), .adc_clk_out(adc_clk_out)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // sample source and reference model
  logic [7:0] exp_q[$];
  int   pat_base = 0, pat_step = 1, pat_idx = 0;
  bit   start_req = 0, ghost_req = 0;
  bit   model_adc = 0, model_busy = 0, model_armed = 0;
  int   model_thr = 0, model_cnt = 0;
  logic last_aclk = 1'b0;

  always @(negedge clk) begin
    start = 1'b0;
    if (!rst) begin
      if (adc_clk_out && !last_aclk) begin
        if (model_busy && model_adc) begin
          if (!(model_armed && int'(adc_sample) < model_thr)) begin
            exp_q.push_back(adc_sample);
            model_armed = 0;
            model_cnt++;
            if (model_cnt == DEPTH) begin
              model_busy = 0;
              chk("R8 done at last store", int'(done), 1);
              chk("R8 busy at last store", int'(busy), 0);
            end
          end
        end
        adc_sample = 8'(pat_base + pat_step * pat_idx);
        pat_idx++;
        if (start_req) begin
          start = 1'b1;
          start_req = 0;
          if (model_adc) begin
            model_busy  = 1;
            model_armed = (trig_level != 9'h1FF);
            model_thr   = int'(trig_level);
            model_cnt   = 0;
          end
        end else if (ghost_req) begin
          start = 1'b1;
          ghost_req = 0;
        end
      end
      last_aclk = adc_clk_out;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send_cmd(input logic [15:0] w);
    step();
    cmd_valid = 1'b1; cmd_word = w;
    step();
    cmd_valid = 1'b0;
    if (w[15:12] == 4'h1) model_adc = (w[7:5] == 3'd0);
  endtask

  task automatic measure(output int p);
    logic prev;
    int c;
    prev = adc_clk_out;
    while (!(adc_clk_out && !prev)) begin prev = adc_clk_out; step(); end
    c = 0;
    prev = adc_clk_out;
    do begin step(); c++; if (adc_clk_out && !prev) break; prev = adc_clk_out; end while (c < 2000);
    p = c;
  endtask

  // monitor: read the buffer and pop the scoreboard
  task automatic read_back(input string tag);
    chk({tag, " entry count"}, exp_q.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      step();
      rd_addr = AW'(i);
      step();
      if (exp_q.size() > 0) chk(tag, int'(rd_data), int'(exp_q.pop_front()));
    end
    exp_q.delete();
  endtask

  task automatic capture(input int thr, input int base, input int stp, input bit ghost, input string tag);
    step();
    pat_base = base; pat_step = stp; pat_idx = 0;
    trig_level = 9'(thr);
    start_req = 1;
    wait (!start_req);
    step();
    chk("R9 done cleared by start", int'(done), 0);
    chk("R9 busy after start", int'(busy), 1);
    if (ghost) begin
      wait (model_cnt >= 5);
      ghost_req = 1;
      wait (!ghost_req);
    end
    wait (!model_busy);
    repeat (3) step();
    read_back(tag);
  endtask

  initial begin
    int p;
    int bad_cnt, rises;
    logic pa;
    repeat (4) step();
    rst = 1'b0;
    step();
    chk("R10 busy after reset", int'(busy), 0);
    chk("R10 done after reset", int'(done), 0);
    chk("R10 drive low after reset", int'(ant_drive), 0);

    measure(p); chk("R2 reset divisor period", p, 192);
    send_cmd(16'h2003); measure(p); chk("R1 divisor 3 period", p, 8);
    send_cmd(16'h2000); measure(p); chk("R1 divisor 0 period", p, 2);
    send_cmd(16'h2001); measure(p); chk("R2 divisor 1 falls back", p, 192);
    send_cmd(16'h212C); measure(p); chk("R2 divisor 300 falls back", p, 192);
    send_cmd(16'h20FF); measure(p); chk("R1 divisor 255 period", p, 512);
    send_cmd(16'h2003);

    // mode off: drive low, ADC clock alive, start ignored
    bad_cnt = 0; rises = 0; pa = adc_clk_out;
    for (int i = 0; i < 64; i++) begin
      step();
      if (ant_drive) bad_cnt++;
      if (adc_clk_out && !pa) rises++;
      pa = adc_clk_out;
    end
    chk("R4 drive low in off mode", bad_cnt, 0);
    chk("R3 ADC clock runs in off mode", int'(rises > 0), 1);
    start_req = 1; wait (!start_req);
    repeat (40) step();
    chk("R5 start ignored in off mode", int'(busy), 0);

    // ADC mode, field on
    send_cmd(16'h1001);
    bad_cnt = 0;
    for (int i = 0; i < 64; i++) begin step(); if (ant_drive !== !adc_clk_out) bad_cnt++; end
    chk("R3 R4 drive antiphase to ADC clock", bad_cnt, 0);

    // passive listening
    send_cmd(16'h1000);
    bad_cnt = 0; rises = 0; pa = adc_clk_out;
    for (int i = 0; i < 64; i++) begin
      step();
      if (ant_drive) bad_cnt++;
      if (adc_clk_out && !pa) rises++;
      pa = adc_clk_out;
    end
    chk("R4 drive low with field off", bad_cnt, 0);
    chk("R3 ADC clock runs with field off", int'(rises > 0), 1);

    capture(511, 7, 3, 0, "R7 untriggered buffer");
    capture(128, 64, 5, 0, "R6 trigger above level");
    capture(80, 16, 16, 0, "R6 trigger exact level");
    capture(0, 200, 9, 0, "R6 threshold zero");
    capture(511, 1, 1, 1, "R9 start during capture");

    // edge-detect mode: start ignored, done kept
    send_cmd(16'h1021);
    bad_cnt = 0;
    for (int i = 0; i < 32; i++) begin step(); if (ant_drive) bad_cnt++; end
    chk("R4 drive low in edge mode", bad_cnt, 0);
    start_req = 1; wait (!start_req);
    repeat (40) step();
    chk("R5 busy stays low in edge mode", int'(busy), 0);
    chk("R5 done kept in edge mode", int'(done), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule